// File: doc/BRIEF.md
# SDRAM Power-up Initialisation Sequencer

This block brings an SDRAM device from power-on to normal operation and then keeps it refreshed. Leaving reset, it drives only NOP cycles for a power-up wait whose length comes from the clock frequency in MHz and the wait in microseconds. It then issues, on an encoded command bus with an address bus, a fixed start-up sequence: precharge of all banks, a mode register write, eight auto-refresh commands, and a second mode register write with no precharge before it. Each command is followed by a parameterised number of NOP cycles that covers the row precharge time, the refresh cycle time or the mode register set delay.

After the second mode write, the block runs ten read-then-write dummy accesses on the first ten words. These go through a simple request/acknowledge port to the memory datapath. It then raises `init_done_o`.

From the second mode write onward, a refresh timer requests a burst of four auto-refreshes at a fixed interval. The interval is the prescale multiplied by the period count. The period count comes from the clock frequency and a 31.2 us target. When the device size input reports a small device, the interval doubles. A refresh burst never overlaps a dummy access.

Top module: `sdram_init_seq`

## Requirements
- R1: `cmd_o` is NOP (code 0) for at least INIT_CYC = CLK_MHZ*INIT_US cycles after reset is released. This is 10000 cycles at the defaults.
- R2: Command codes on `cmd_o` are 0 NOP, 1 precharge-all, 2 auto-refresh and 3 mode-set. The first command is precharge-all with `cmd_addr_o` = 0x400, which is bit AP_BIT = 10 alone. The second command is a mode-set.
- R3: Exactly eight auto-refresh commands follow the first mode-set. The next command is a second mode-set, with no precharge between them.
- R4: During every mode-set, `cmd_addr_o` carries the mode value 0x22 (CAS latency 2, sequential, burst length 4) shifted left by 2, which is 0x088. During an auto-refresh, `cmd_addr_o` is 0.
- R5: The number of cycles from one command to the next is TRP_CYC+1 after a precharge and TMRD_CYC+1 after a mode-set. It is TRFC_CYC+1 after any auto-refresh that another refresh or mode-set follows in sequence. The defaults are 3, 3 and 5.
- R6: After the second mode-set, the block issues ten read/write pairs on words 0 to 9 in ascending order. Each word is read (`acc_we_o` = 0) and then written (`acc_we_o` = 1) with the data just read. A request holds its address and direction until `acc_ack_i`.
- R7: `init_done_o` is 0 in reset and stays 0 until the tenth write is acknowledged. It then goes to 1 and stays there.
- R8: No periodic refresh is issued before the second mode-set.
- R9: Periodic refresh comes as bursts of four auto-refreshes. When the size input is above SMALL_LIMIT_MB (32), consecutive bursts start PRESCALE*PERIOD cycles apart, which is 8*195 = 1560 cycles at the defaults.
- R10: When `size_mb_i` <= 32, the burst interval doubles to 3120 cycles. A size of 32 gives the slow rate and a size of 33 gives the fast rate.
- R11: No auto-refresh is issued while `acc_req_o` is high. A refresh that falls due during an access waits until that access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_mb_i | input | SIZE_W | Detected device size in MB, used to pick the refresh rate |
| cmd_o | output | 2 | Encoded SDRAM command |
| cmd_addr_o | output | ADDR_W | Address lines driven with the command |
| acc_req_o | output | 1 | Dummy access request |
| acc_we_o | output | 1 | 1 = write, 0 = read for the current request |
| acc_addr_o | output | IDX_W | Word index of the dummy access |
| acc_wdata_o | output | DATA_W | Write data (the word read just before) |
| acc_rdata_i | input | DATA_W | Read data, valid with acknowledge |
| acc_ack_i | input | 1 | Access acknowledge, one cycle |
| init_done_o | output | 1 | Initialisation complete |

## Verification
The bench measures the exact spacing between commands. A gap counter that is off by one would shift every later command and break the spacing checks. It also counts the refreshes between the two mode writes: a design that started periodic refresh early, or lost one of the two groups of four, would show the wrong number there.

The refresh interval is checked at a size of 33 (fast) and a size of 32 (slow). A comparison at the wrong end of the size boundary would give the wrong interval at one of these two points.

One run slows the acknowledge so much that a refresh falls due during the dummy phase. A design that did not hold the refresh back would issue an auto-refresh while a request is open. A design that lost the pending refresh would skip a burst, and the interval checks would then fail.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

   typedef enum logic [1:0] {
      CMD_NOP           = 2'd0,
      CMD_PRECHARGE_ALL = 2'd1,
      CMD_AUTO_REFRESH  = 2'd2,
      CMD_MODE_SET      = 2'd3
   } sd_cmd_e;

   typedef enum logic [3:0] {
      ST_POWER,
      ST_PRE,
      ST_PRE_GAP,
      ST_MRS1,
      ST_MRS1_GAP,
      ST_IREF,
      ST_IREF_GAP,
      ST_MRS2,
      ST_MRS2_GAP,
      ST_DUMMY,
      ST_PREF,
      ST_PREF_GAP,
      ST_RUN
   } seq_state_e;

   typedef enum logic [1:0] {
      ACC_IDLE,
      ACC_READ,
      ACC_WRITE
   } acc_state_e;

endpackage

// File: rtl/sdinit_refresh_timer.sv
module sdinit_refresh_timer #(
   parameter int PRESCALE       = 8,
   parameter int PERIOD         = 195,
   parameter int SIZE_W         = 10,
   parameter int SMALL_LIMIT_MB = 32,
   parameter bit SIZE_ADAPT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [SIZE_W-1:0] size_mb_i,
   output logic              tick_o
);
   localparam int PRE_W = $clog2(2*PRESCALE + 1);
   localparam int PER_W = $clog2(PERIOD + 1);

   logic             slow;
   logic [PRE_W-1:0] pre_lim;
   logic [PRE_W-1:0] pre_q;
   logic [PER_W-1:0] per_q;

   generate
      if (SIZE_ADAPT) begin : g_adapt
         assign slow = (size_mb_i <= SIZE_W'(SMALL_LIMIT_MB));
      end else begin : g_fixed
         logic unused_size;
         assign unused_size = ^size_mb_i;
         assign slow = 1'b0;
      end
   endgenerate

   assign pre_lim = slow ? PRE_W'(2*PRESCALE - 1) : PRE_W'(PRESCALE - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         per_q  <= '0;
         tick_o <= 1'b0;
      end else if (!en_i) begin
         pre_q  <= '0;
         per_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= 1'b0;
         if (pre_q >= pre_lim) begin
            pre_q <= '0;
            if (per_q == PER_W'(PERIOD - 1)) begin
               per_q  <= '0;
               tick_o <= 1'b1;
            end else begin
               per_q <= per_q + 1'b1;
            end
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sdinit_dummy_engine.sv
module sdinit_dummy_engine
   import sdinit_pkg::*;
#(
   parameter int N_DUMMY = 10,
   parameter int IDX_W   = 4,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              req_o,
   output logic              we_o,
   output logic [IDX_W-1:0]  addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              busy_o,
   output logic              all_done_o
);
   acc_state_e        st_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] data_q;

   assign all_done_o = (idx_q == IDX_W'(N_DUMMY));
   assign busy_o     = (st_q != ACC_IDLE);
   assign req_o      = (st_q == ACC_READ) || (st_q == ACC_WRITE);
   assign we_o       = (st_q == ACC_WRITE);
   assign addr_o     = idx_q;
   assign wdata_o    = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ACC_IDLE;
         idx_q  <= '0;
         data_q <= '0;
      end else begin
         case (st_q)
            ACC_IDLE: if (go_i && !all_done_o) st_q <= ACC_READ;
            ACC_READ: if (ack_i) begin
               data_q <= rdata_i;
               st_q   <= ACC_WRITE;
            end
            ACC_WRITE: if (ack_i) begin
               idx_q <= idx_q + 1'b1;
               st_q  <= ACC_IDLE;
            end
            default: st_q <= ACC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdinit_cmd_decode.sv
module sdinit_cmd_decode
   import sdinit_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int AP_BIT     = 10,
   parameter int MODE_VAL   = 'h22,
   parameter int MODE_SHIFT = 2,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_e        st_i,
   output logic [1:0]        cmd_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(MODE_VAL << MODE_SHIFT);
   localparam logic [ADDR_W-1:0] AP_WORD   = ADDR_W'(1) << AP_BIT;

   sd_cmd_e           cmd_d;
   logic [ADDR_W-1:0] addr_d;

   always_comb begin
      cmd_d  = CMD_NOP;
      addr_d = '0;
      case (st_i)
         ST_PRE:  begin cmd_d = CMD_PRECHARGE_ALL; addr_d = AP_WORD;   end
         ST_MRS1,
         ST_MRS2: begin cmd_d = CMD_MODE_SET;      addr_d = MODE_WORD; end
         ST_IREF,
         ST_PREF: cmd_d = CMD_AUTO_REFRESH;
         default: ;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cmd_o  <= CMD_NOP;
               addr_o <= '0;
            end else begin
               cmd_o  <= cmd_d;
               addr_o <= addr_d;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign cmd_o  = cmd_d;
         assign addr_o = addr_d;
      end
   endgenerate
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdinit_pkg::*;
#(
   parameter int CLK_MHZ        = 50,
   parameter int INIT_US        = 200,
   parameter int REFRESH_NS     = 31200,
   parameter int PRESCALE       = 8,
   parameter int TRP_CYC        = 2,
   parameter int TRFC_CYC       = 4,
   parameter int TMRD_CYC       = 2,
   parameter int INIT_REFS      = 8,
   parameter int BURST_REFS     = 4,
   parameter int N_DUMMY        = 10,
   parameter int ADDR_W         = 13,
   parameter int DATA_W         = 32,
   parameter int AP_BIT         = 10,
   parameter int MODE_VAL       = 'h22,
   parameter int MODE_SHIFT     = 2,
   parameter int SIZE_W         = 10,
   parameter int SMALL_LIMIT_MB = 32,
   parameter bit SIZE_ADAPT     = 1'b1,
   parameter bit REG_OUT        = 1'b1,
   localparam int IDX_W         = $clog2(N_DUMMY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SIZE_W-1:0] size_mb_i,
   output logic [1:0]        cmd_o,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic              acc_req_o,
   output logic              acc_we_o,
   output logic [IDX_W-1:0]  acc_addr_o,
   output logic [DATA_W-1:0] acc_wdata_o,
   input  logic [DATA_W-1:0] acc_rdata_i,
   input  logic              acc_ack_i,
   output logic              init_done_o
);
   localparam int INIT_CYC = CLK_MHZ * INIT_US;
   localparam int PERIOD   = (CLK_MHZ * REFRESH_NS) / (1000 * PRESCALE);
   localparam int GAP_MAX  = (TRP_CYC > TRFC_CYC) ?
                             ((TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC) :
                             ((TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC);
   localparam int WAIT_MAX = (INIT_CYC > GAP_MAX) ? INIT_CYC : GAP_MAX;
   localparam int CNT_W    = $clog2(WAIT_MAX + 1);
   localparam int REF_MAX  = (INIT_REFS > BURST_REFS) ? INIT_REFS : BURST_REFS;
   localparam int RL_W     = $clog2(REF_MAX + 1);

   generate
      if (TRP_CYC < 1 || TRFC_CYC < 1 || TMRD_CYC < 1) begin : g_bad_gap
         $error("command gaps must be at least one cycle");
      end
      if (INIT_REFS < 1 || BURST_REFS < 1) begin : g_bad_refs
         $error("refresh counts must be at least one");
      end
      if (AP_BIT >= ADDR_W) begin : g_bad_ap
         $error("precharge-all bit outside the address bus");
      end
      if (PERIOD < 1 || PRESCALE < 1) begin : g_bad_period
         $error("refresh period rounds to zero");
      end
      if (N_DUMMY < 1) begin : g_bad_dummy
         $error("at least one dummy access is needed");
      end
   endgenerate

   seq_state_e       st_q;
   logic [CNT_W-1:0] wait_q;
   logic [RL_W-1:0]  ref_left_q;
   logic             timer_en_q;
   logic             pend_q;
   logic             done_q;
   logic             tick;
   logic             take_ref;
   logic             eng_busy;
   logic             eng_all_done;
   logic             eng_go;
   logic             wait_zero;

   assign wait_zero   = (wait_q == '0);
   assign take_ref    = pend_q && ((st_q == ST_RUN) || ((st_q == ST_DUMMY) && !eng_busy));
   assign eng_go      = (st_q == ST_DUMMY) && !pend_q;
   assign init_done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_POWER;
         wait_q     <= CNT_W'(INIT_CYC - 1);
         ref_left_q <= '0;
         timer_en_q <= 1'b0;
         pend_q     <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         pend_q <= tick | (pend_q & ~take_ref);
         case (st_q)
            ST_POWER: begin
               if (wait_zero) st_q <= ST_PRE;
               else           wait_q <= wait_q - 1'b1;
            end
            ST_PRE: begin
               st_q   <= ST_PRE_GAP;
               wait_q <= CNT_W'(TRP_CYC - 1);
            end
            ST_PRE_GAP: begin
               if (wait_zero) st_q <= ST_MRS1;
               else           wait_q <= wait_q - 1'b1;
            end
            ST_MRS1: begin
               st_q   <= ST_MRS1_GAP;
               wait_q <= CNT_W'(TMRD_CYC - 1);
            end
            ST_MRS1_GAP: begin
               if (wait_zero) begin
                  st_q       <= ST_IREF;
                  ref_left_q <= RL_W'(INIT_REFS - 1);
               end else begin
                  wait_q <= wait_q - 1'b1;
               end
            end
            ST_IREF: begin
               st_q   <= ST_IREF_GAP;
               wait_q <= CNT_W'(TRFC_CYC - 1);
            end
            ST_IREF_GAP: begin
               if (!wait_zero) begin
                  wait_q <= wait_q - 1'b1;
               end else if (ref_left_q == '0) begin
                  st_q <= ST_MRS2;
               end else begin
                  ref_left_q <= ref_left_q - 1'b1;
                  st_q       <= ST_IREF;
               end
            end
            ST_MRS2: begin
               st_q   <= ST_MRS2_GAP;
               wait_q <= CNT_W'(TMRD_CYC - 1);
            end
            ST_MRS2_GAP: begin
               if (wait_zero) begin
                  st_q       <= ST_DUMMY;
                  timer_en_q <= 1'b1;
               end else begin
                  wait_q <= wait_q - 1'b1;
               end
            end
            ST_DUMMY: begin
               if (take_ref) begin
                  st_q       <= ST_PREF;
                  ref_left_q <= RL_W'(BURST_REFS - 1);
               end else if (eng_all_done && !eng_busy) begin
                  st_q   <= ST_RUN;
                  done_q <= 1'b1;
               end
            end
            ST_PREF: begin
               st_q   <= ST_PREF_GAP;
               wait_q <= CNT_W'(TRFC_CYC - 1);
            end
            ST_PREF_GAP: begin
               if (!wait_zero) begin
                  wait_q <= wait_q - 1'b1;
               end else if (ref_left_q == '0) begin
                  st_q <= done_q ? ST_RUN : ST_DUMMY;
               end else begin
                  ref_left_q <= ref_left_q - 1'b1;
                  st_q       <= ST_PREF;
               end
            end
            ST_RUN: begin
               if (take_ref) begin
                  st_q       <= ST_PREF;
                  ref_left_q <= RL_W'(BURST_REFS - 1);
               end
            end
            default: st_q <= ST_POWER;
         endcase
      end
   end

   sdinit_refresh_timer #(
      .PRESCALE      (PRESCALE),
      .PERIOD        (PERIOD),
      .SIZE_W        (SIZE_W),
      .SMALL_LIMIT_MB(SMALL_LIMIT_MB),
      .SIZE_ADAPT    (SIZE_ADAPT)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (timer_en_q),
      .size_mb_i(size_mb_i),
      .tick_o   (tick)
   );

   sdinit_dummy_engine #(
      .N_DUMMY(N_DUMMY),
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W)
   ) u_dummy (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (eng_go),
      .ack_i     (acc_ack_i),
      .rdata_i   (acc_rdata_i),
      .req_o     (acc_req_o),
      .we_o      (acc_we_o),
      .addr_o    (acc_addr_o),
      .wdata_o   (acc_wdata_o),
      .busy_o    (eng_busy),
      .all_done_o(eng_all_done)
   );

   sdinit_cmd_decode #(
      .ADDR_W    (ADDR_W),
      .AP_BIT    (AP_BIT),
      .MODE_VAL  (MODE_VAL),
      .MODE_SHIFT(MODE_SHIFT),
      .REG_OUT   (REG_OUT)
   ) u_decode (
      .clk   (clk),
      .rst_n (rst_n),
      .st_i  (st_q),
      .cmd_o (cmd_o),
      .addr_o(cmd_addr_o)
   );
endmodule

// File: rtl/sdinit_checker.sv
module sdinit_checker #(
   parameter int CLK_MHZ    = 50,
   parameter int INIT_US    = 200,
   parameter int TRFC_CYC   = 4,
   parameter int N_DUMMY    = 10,
   parameter int ADDR_W     = 13,
   parameter int AP_BIT     = 10,
   parameter int MODE_VAL   = 'h22,
   parameter int MODE_SHIFT = 2,
   localparam int IDX_W     = $clog2(N_DUMMY + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd_o,
   input logic [ADDR_W-1:0] cmd_addr_o,
   input logic              acc_req_o,
   input logic              acc_we_o,
   input logic [IDX_W-1:0]  acc_addr_o,
   input logic              acc_ack_i,
   input logic              init_done_o
);
   localparam int INIT_CYC = CLK_MHZ * INIT_US;
   localparam int SR_W     = $clog2(INIT_CYC + 1);

   logic [SR_W-1:0]  since_rst;
   logic [15:0]      nops;
   logic             last_ref;
   logic [IDX_W:0]   wr_acks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
         nops      <= '0;
         last_ref  <= 1'b0;
         wr_acks   <= '0;
      end else begin
         if (since_rst != SR_W'(INIT_CYC)) since_rst <= since_rst + 1'b1;
         if (cmd_o != 2'd0) begin
            nops     <= '0;
            last_ref <= (cmd_o == 2'd2);
         end else if (nops != 16'hFFFF) begin
            nops <= nops + 1'b1;
         end
         if (acc_req_o && acc_we_o && acc_ack_i && wr_acks != (IDX_W+1)'(N_DUMMY))
            wr_acks <= wr_acks + 1'b1;
      end
   end

   a_r1_quiet_powerup: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < SR_W'(INIT_CYC)) |-> (cmd_o == 2'd0));

   a_r2_precharge_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd1) |-> (cmd_addr_o == (ADDR_W'(1) << AP_BIT)));

   a_r4_mode_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd3) |-> (cmd_addr_o == ADDR_W'(MODE_VAL << MODE_SHIFT)));

   a_r5_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_o != 2'd0) && last_ref) |-> (nops >= 16'(TRFC_CYC)));

   a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req_o && !acc_ack_i) |=> (acc_req_o && $stable(acc_addr_o) && $stable(acc_we_o)));

   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_done_o |=> init_done_o);

   a_r7_done_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
      init_done_o |-> (wr_acks == (IDX_W+1)'(N_DUMMY)));

   a_r11_no_refresh_in_access: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req_o |-> (cmd_o != 2'd2));
endmodule

bind sdram_init_seq sdinit_checker #(
   .CLK_MHZ   (CLK_MHZ),
   .INIT_US   (INIT_US),
   .TRFC_CYC  (TRFC_CYC),
   .N_DUMMY   (N_DUMMY),
   .ADDR_W    (ADDR_W),
   .AP_BIT    (AP_BIT),
   .MODE_VAL  (MODE_VAL),
   .MODE_SHIFT(MODE_SHIFT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_o      (cmd_o),
   .cmd_addr_o (cmd_addr_o),
   .acc_req_o  (acc_req_o),
   .acc_we_o   (acc_we_o),
   .acc_addr_o (acc_addr_o),
   .acc_ack_i  (acc_ack_i),
   .init_done_o(init_done_o)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
   localparam int INIT_CYC  = 10000;
   localparam int TRP       = 2;
   localparam int TRFC      = 4;
   localparam int TMRD      = 2;
   localparam int FAST_IV   = 1560;
   localparam int SLOW_IV   = 3120;
   localparam int MODE_ADDR = 'h088;
   localparam int PRE_ADDR  = 'h400;
   localparam int NDUM      = 10;
   localparam int BURSTS    = 5;
   localparam int GAP_INIT  = -2;
   localparam int GAP_HEAD  = -1;

   typedef struct {
      int    cmd;
      int    addr;
      int    gap;
      string tag;
   } cmd_item_t;

   typedef struct {
      bit          we;
      int          addr;
      logic [31:0] data;
   } acc_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  size_mb = 10'd64;
   logic [1:0]  cmd;
   logic [12:0] cmd_addr;
   logic        acc_req, acc_we, acc_ack = 1'b0, init_done;
   logic [3:0]  acc_addr;
   logic [31:0] acc_wdata, acc_rdata = '0;

   int n_chk = 0, n_fail = 0;
   int cyc = 0, last_cmd_cyc = 0, rst_cyc = 0;
   int ref_in_acc = 0, wr_acks = 0, ack_delay = 0, run_id = 0;
   bit done_prev = 1'b0;
   bit finished = 1'b0;
   int head_t[$];
   cmd_item_t cmd_q[$];
   acc_item_t acc_q[$];

   always #2 clk = ~clk;

   sdram_init_seq u_sdram_init_seq (
      .clk(clk), .rst_n(rst_n), .size_mb_i(size_mb),
      .cmd_o(cmd), .cmd_addr_o(cmd_addr),
      .acc_req_o(acc_req), .acc_we_o(acc_we), .acc_addr_o(acc_addr),
      .acc_wdata_o(acc_wdata), .acc_rdata_i(acc_rdata), .acc_ack_i(acc_ack),
      .init_done_o(init_done)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] word_of(input int run, input int i);
      return 32'h5A00_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(run << 20);
   endfunction

   task automatic push_cmd(input int c, input int a, input int g, input string t);
      cmd_item_t it;
      it.cmd = c; it.addr = a; it.gap = g; it.tag = t;
      cmd_q.push_back(it);
   endtask

   always @(posedge clk) cyc++;

   // scoreboard monitor for the command bus
   always @(negedge clk) begin
      cmd_item_t it;
      int gap;
      if (rst_n && cmd != 2'd0) begin
         gap = cyc - last_cmd_cyc;
         if (cmd == 2'd2 && acc_req) ref_in_acc++;
         if (cmd_q.size() == 0) begin
            chk(1'b0, "R8 unexpected command", cmd, 0);
         end else begin
            it = cmd_q.pop_front();
            chk(cmd == it.cmd[1:0], {it.tag, " code"}, cmd, it.cmd);
            chk(cmd_addr == it.addr[12:0], {"R4 addr ", it.tag}, cmd_addr, it.addr);
            if (it.gap == GAP_INIT)
               chk(cyc - rst_cyc >= INIT_CYC, "R1 power-up wait", cyc - rst_cyc, INIT_CYC);
            else if (it.gap == GAP_HEAD)
               head_t.push_back(cyc);
            else
               chk(gap == it.gap, {"R5 gap ", it.tag}, gap, it.gap);
         end
         last_cmd_cyc = cyc;
      end
   end

   // init_done rising edge monitor
   always @(negedge clk) begin
      if (!rst_n) done_prev = 1'b0;
      else begin
         if (init_done && !done_prev)
            chk(wr_acks == NDUM, "R7 done after tenth write", wr_acks, NDUM);
         if (!init_done && done_prev)
            chk(1'b0, "R7 done dropped", 0, 1);
         done_prev = init_done;
      end
   end

   // access responder and scoreboard
   initial begin
      acc_item_t it;
      forever begin
         @(negedge clk);
         if (rst_n && acc_req) begin
            repeat (ack_delay) @(negedge clk);
            if (acc_q.size() == 0) begin
               chk(1'b0, "R6 unexpected access", acc_addr, 0);
            end else begin
               it = acc_q.pop_front();
               chk(acc_we == it.we, "R6 direction", acc_we, it.we);
               chk(acc_addr == it.addr[3:0], "R6 word index", acc_addr, it.addr);
               if (it.we) begin
                  chk(acc_wdata == it.data, "R6 write-back data", acc_wdata, it.data);
                  wr_acks++;
               end
               acc_rdata = it.data;
            end
            acc_ack = 1'b1;
            @(negedge clk);
            acc_ack = 1'b0;
         end
      end
   end

   task automatic run_case(input int size, input int dly, input string lbl);
      acc_item_t ai;
      int iv;
      rst_n = 1'b0;
      size_mb = 10'(size);
      ack_delay = dly;
      run_id++;
      cmd_q.delete(); acc_q.delete(); head_t.delete();
      wr_acks = 0; ref_in_acc = 0;
      repeat (3) @(negedge clk);
      chk(cmd == 2'd0 && !acc_req, {"R1 reset outputs ", lbl}, cmd, 0);
      chk(!init_done, {"R7 reset done low ", lbl}, init_done, 0);
      push_cmd(1, PRE_ADDR, GAP_INIT, "R2 precharge first");
      push_cmd(3, MODE_ADDR, TRP + 1, "R2 mode-set after precharge");
      for (int k = 0; k < 8; k++)
         push_cmd(2, 0, (k == 0) ? TMRD + 1 : TRFC + 1, "R3 init refresh");
      push_cmd(3, MODE_ADDR, TRFC + 1, "R3 second mode-set");
      for (int b = 0; b < BURSTS; b++) begin
         push_cmd(2, 0, GAP_HEAD, "R9 burst head");
         for (int k = 1; k < 4; k++) push_cmd(2, 0, TRFC + 1, "R9 burst refresh");
      end
      for (int i = 0; i < NDUM; i++) begin
         ai.addr = i; ai.data = word_of(run_id, i);
         ai.we = 1'b0; acc_q.push_back(ai);
         ai.we = 1'b1; acc_q.push_back(ai);
      end
      @(negedge clk);
      rst_n = 1'b1;
      rst_cyc = cyc;
      last_cmd_cyc = cyc;
      repeat (INIT_CYC / 2) @(negedge clk);
      chk(!init_done, {"R7 low during power-up ", lbl}, init_done, 0);
      while (cmd_q.size() != 0) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(init_done, {"R7 done high ", lbl}, init_done, 1);
      chk(acc_q.size() == 0, {"R6 all accesses made ", lbl}, acc_q.size(), 0);
      chk(ref_in_acc == 0, {"R11 refresh during access ", lbl}, ref_in_acc, 0);
      iv = (size <= 32) ? SLOW_IV : FAST_IV;
      for (int k = 2; k < BURSTS; k++)
         chk(head_t[k] - head_t[k-1] == iv,
             {(size <= 32) ? "R10 slow interval " : "R9 fast interval ", lbl},
             head_t[k] - head_t[k-1], iv);
   endtask

   initial begin
      run_case(64, 0, "size64");
      run_case(33, 100, "size33 slow ack");
      run_case(32, 1, "size32");
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule